// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Display Driver

This block drives the 32 segment or dot lines of a display from a serial stream. Bits arrive one at a time on a data input. Each rising edge of a separate shift clock moves them into a chain of shift stages. A holding stage sits between the shift chain and the outputs. The holding stage lets the shift contents through while the latch control is high, and it freezes them when that control falls. The previous frame therefore stays on the lines while the next one is being shifted in. A blanking input pulls every line low at once and does not disturb any stored data.

The last shift stage is also brought out as a serial output, so several drivers can be chained on one data stream. A 64-bit stream sent through two chained drivers leaves its first 32 bits in the downstream driver. The whole block runs on one system clock. The shift clock is treated as an edge-qualified enable, and the holding stage is a register that reloads on every system cycle while the latch control is high.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears every shift stage and every holding bit to 0, so all lines and the serial output read 0.
- R2: A shift happens only in a system cycle where the shift clock is sampled high after having been sampled low. In that shift, stage 1 (bit 0) takes the data input and stage k takes the old value of stage k-1. A shift clock held high for several cycles causes only one shift.
- R3: The serial output always equals the last stage (bit CHANNELS-1). The latch control and the blanking input have no effect on it.
- R4: While the latch control is high, the holding bits equal the shift stages, including a shift made in that same cycle.
- R5: While the latch control is low, the holding bits keep the value they had when the control fell, even while shifting continues.
- R6: With blanking low, line n (bit n-1 of the line bus) shows holding bit n. With blanking high, every line reads 0.
- R7: Latch and blanking activity with no shift-clock edge leaves the shift stages unchanged.
- R8: In a 32-bit frame, the first bit shifted in appears on the top line (bit 31) and the last bit shifted in appears on line 1 (bit 0).
- R9: With two drivers chained (the downstream data input taken from the upstream serial output), frame bit k of a 64-bit frame, counted from 0 in shift order, appears on downstream bit 31-k for k below 32 and on upstream bit 63-k otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Shift clock; a low-to-high change shifts once |
| din | input | 1 | Serial data input |
| latch_en | input | 1 | High: holding stage follows shift stages; low: hold |
| blank | input | 1 | High forces every line low |
| q | output | CHANNELS | Parallel line outputs, bit 0 is line 1 |
| sout | output | 1 | Serial cascade output, the last shift stage |

## Verification
A corrupted shift stage shows up on the serial output. It appears after as many further shifts as that stage is from the end of the chain. If the latch control is high, it also appears on the lines in the very next cycle. A holding bit that leaks while the latch control is low changes a line in the cycle of the offending shift, unless blanking hides it. The bench therefore compares both chained drivers against a bit-queue model in every cycle. It also checks the frame placement explicitly after a full 64-bit load.

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int CHANNELS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_clk,
  input  logic                din,
  input  logic                latch_en,
  input  logic                blank,
  output logic [CHANNELS-1:0] q,
  output logic                sout
);

  localparam int LAST = CHANNELS - 1;

  logic [LAST:0] sr;
  logic [LAST:0] hold;
  logic          sclk_d;
  logic          shift_rise;
  logic [LAST:0] sr_next;

  assign shift_rise = shift_clk & ~sclk_d;
  assign sr_next    = shift_rise ? {sr[LAST-1:0], din} : sr;

  always_ff @(posedge clk) begin
    sclk_d <= shift_clk;
    if (rst) begin
      sr   <= '0;
      hold <= '0;
    end else begin
      sr <= sr_next;
      if (latch_en) hold <= sr_next;
    end
  end

  assign q    = blank ? '0 : hold;
  assign sout = sr[LAST];

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (sr == '0 && hold == '0));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_rise |=> (sr[0] == $past(din)));

  // R7
  no_shift_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_rise |=> $stable(sr));

  // R3
  cascade_out_chk: assert property (@(posedge clk) disable iff (rst)
    shift_rise |=> (sout == $past(sr[LAST-1])));

  // R4
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (hold == sr));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(hold));

endmodule

// File: tb/serial_latch_driver_bench.sv
module serial_latch_driver_bench;
  localparam int PERIOD = 10;
  localparam int N = 32;

  logic clk = 0;
  logic rst = 1;
  logic shift_clk = 0;
  logic din = 0;
  logic latch_en = 0;
  logic blank = 0;
  logic [N-1:0] q0, q1;
  logic sout0, sout1;

  int vectors = 0;
  int misses = 0;
  bit done = 0;
  string tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  serial_latch_driver #(.CHANNELS(N)) u_serial_latch_driver (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .din(din),
    .latch_en(latch_en), .blank(blank), .q(q0), .sout(sout0));

  serial_latch_driver #(.CHANNELS(N)) u_serial_latch_driver_tail (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .din(sout0),
    .latch_en(latch_en), .blank(blank), .q(q1), .sout(sout1));

  bit m_sr0[$], m_sr1[$];
  bit m_lat0[N], m_lat1[N];
  bit m_prev = 0;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_sr0.push_back(0);
      m_sr1.push_back(0);
    end
  end

  always @(posedge clk) begin
    bit rise, carry;
    rise = shift_clk && !m_prev;
    m_prev = shift_clk;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_sr0[i] = 0; m_sr1[i] = 0; m_lat0[i] = 0; m_lat1[i] = 0;
      end
    end else begin
      if (rise) begin
        carry = m_sr0[N-1];
        m_sr0.push_front(din);  void'(m_sr0.pop_back());
        m_sr1.push_front(carry); void'(m_sr1.pop_back());
      end
      if (latch_en)
        for (int i = 0; i < N; i++) begin
          m_lat0[i] = m_sr0[i]; m_lat1[i] = m_sr1[i];
        end
    end
  end

  task automatic cmp(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [N-1:0] e0, e1;
    #(PERIOD/4);
    if (!done) begin
      for (int i = 0; i < N; i++) begin
        e0[i] = blank ? 1'b0 : m_lat0[i];
        e1[i] = blank ? 1'b0 : m_lat1[i];
      end
      cmp(tag, "q upstream", q0, e0);
      cmp(tag, "q downstream", q1, e1);
      cmp(tag, "sout upstream", {{(N-1){1'b0}}, sout0}, {{(N-1){1'b0}}, m_sr0[N-1]});
      cmp(tag, "sout downstream", {{(N-1){1'b0}}, sout1}, {{(N-1){1'b0}}, m_sr1[N-1]});
    end
  end

  task automatic shift_bit(bit b);
    @(negedge clk); din = b; shift_clk = 1;
    @(negedge clk); shift_clk = 0;
  endtask

  task automatic pulse_latch();
    @(negedge clk); latch_en = 1;
    @(negedge clk); latch_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [63:0] FRAME = 64'hC3A5_0F96_1E2D_B478;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [N-1:0] x0, x1;
    tag = "R1";
    idle(3);
    cmp("R1", "reset q", q0, '0);
    cmp("R1", "reset sout", {{(N-1){1'b0}}, sout1}, '0);
    @(negedge clk); rst = 0;

    tag = "R2";
    shift_bit(1); shift_bit(0); shift_bit(1);
    @(negedge clk); din = 1; shift_clk = 1;
    idle(4);
    @(negedge clk); shift_clk = 0; din = 0;
    idle(2);

    tag = "R8";
    for (int k = 0; k < 64; k++) shift_bit(FRAME[k]);
    tag = "R9";
    pulse_latch();
    idle(1);
    for (int k = 0; k < 64; k++)
      if (k < 32) x1[31-k] = FRAME[k]; else x0[63-k] = FRAME[k];
    cmp("R9", "chained frame downstream", q1, x1);
    cmp("R8", "frame placement upstream", q0, x0);

    tag = "R5";
    for (int k = 0; k < 10; k++) shift_bit(k[0] ^ k[2]);
    cmp("R5", "held during shift", q0, x0);

    tag = "R4";
    @(negedge clk); latch_en = 1;
    for (int k = 0; k < 12; k++) shift_bit(k[1]);
    @(negedge clk); latch_en = 0;
    for (int k = 0; k < 5; k++) shift_bit(1);

    tag = "R6";
    @(negedge clk); blank = 1;
    idle(1);
    cmp("R6", "blanked lines", q0, '0);
    tag = "R3";
    for (int k = 0; k < 6; k++) shift_bit(k[0]);
    @(negedge clk); blank = 0;

    tag = "R7";
    repeat (4) begin
      @(negedge clk); latch_en = 1; blank = 1;
      @(negedge clk); latch_en = 0; blank = 0;
    end
    pulse_latch();
    idle(2);

    tag = "R1";
    @(negedge clk); rst = 1;
    idle(2);
    @(negedge clk); rst = 0;
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule